// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Receiver

This block is a write-only serial programming port feeding a bank of internal configuration registers. An external controller drives a serial clock, an active-low chip select and a serial data line. While chip select is low, each rising serial clock edge shifts one data bit in. When chip select returns high, the block checks the frame length and decodes the address. It then copies the 14-bit data field into the register that the trailing 4-bit address selects.

The three serial inputs are taken into the system clock domain through two-flop synchronizers, and all edge detection happens there. The system clock must therefore run at least four times faster than the serial clock. Every register is always visible on a flat parallel output bus. A one-cycle write strobe reports each committed write together with its address and data. A one-cycle error strobe reports each discarded frame.

Top module: `serial_cfg_rx`

## Requirements
- R1: A frame of exactly 18 bits is received as a 14-bit data field followed by a 4-bit address. When chip select rises, the data field is written into register `address`, which appears on `cfg_regs[address*14 +: 14]`.
- R2: Bits arrive most significant bit first. The first bit after chip select falls is data bit 13, and the last bit of the frame is address bit 0.
- R3: Serial clock rising edges while chip select is high shift nothing. They cause no write strobe, no error strobe and no change to a frame that follows.
- R4: A frame commits correctly whether the serial clock is idling high or idling low at the moment chip select rises.
- R5: A frame that ends with a bit count other than 18 (short, long or empty) is discarded. It raises `frame_err` for exactly one cycle, gives no `wr_stb`, and leaves every register unchanged.
- R6: Each committed frame raises `wr_stb` for exactly one cycle. In that cycle `wr_addr` holds the address field and `wr_data` holds the 14-bit data field as received, and `frame_err` stays low.
- R7: The bit counter clears while chip select is high, so a frame that follows a discarded frame is received correctly.
- R8: Registers 12 to 15 keep only the low 8 data bits. Their upper 6 bits read as zero whatever the frame carries. Registers 0 to 11 keep all 14 bits.
- R9: While `rst_n` is low at a rising `clk` edge, all registers clear to zero and both strobes go low. Reset is synchronous and active low.
- R10: A write changes only the addressed register. All other registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_csn | input | 1 | Active-low frame select |
| ser_dat | input | 1 | Serial data, MSB first |
| cfg_regs | output | 224 | All 16 registers, register i at bits [i*14 +: 14] |
| wr_stb | output | 1 | One-cycle pulse for a committed write |
| wr_addr | output | 4 | Address of the committed write |
| wr_data | output | 14 | Data field of the committed write, unmasked |
| frame_err | output | 1 | One-cycle pulse for a discarded frame |

## Verification
A vector table of frames covers several patterns. All-ones data exposes a lost bit. Alternating data such as 0x2AAA against 0x1555 shows whether the bit order is reversed or shifted. A lone top bit or a lone bottom bit shows whether the frame has slipped by one position. The table alternates the serial clock idle level at frame end and writes to both wide and narrow registers. An overwrite of register 0 shows that a later frame replaces an earlier one. Directed tests send 17-bit, 19-bit and empty frames, and each of these must raise the error strobe and leave the bank intact. They also send serial clock pulses while the frame is deselected, to tell an ignored edge from a stray shift. A good frame follows each of these tests, to show that the counter was cleared.

// File: rtl/serial_cfg_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and helpers for the serial configuration receiver.
// Assumes: widths stay at or below 32 bits so masks fit in a 32-bit result.
package serial_cfg_pkg;

    localparam int unsigned DEF_DATA_W   = 14;
    localparam int unsigned DEF_ADDR_W   = 4;
    localparam int unsigned DEF_SYNC_N   = 2;
    localparam int unsigned DEF_WIDE_CNT = 12;
    localparam int unsigned DEF_NARROW_W = 8;

    // Build a mask with the low 'keep' bits set.
    function automatic logic [31:0] low_mask(input int unsigned keep);
        logic [31:0] m;
        m = '0;
        for (int unsigned b = 0; b < 32; b++) begin
            if (b < keep) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/serial_cfg_sync.sv
`timescale 1ns/1ps
// Module: serial_cfg_sync
// Multi-stage synchronizer for a group of asynchronous single-bit inputs.
// Assumes: each bit is independent. The bits are not coherent as a bus.
// The reset value is chosen per bit so that no false edge appears after reset.
module serial_cfg_sync #(
    parameter int unsigned WIDTH    = 3,
    parameter int unsigned STAGES   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/serial_cfg_shifter.sv
`timescale 1ns/1ps
// Module: serial_cfg_shifter
// Detects edges on the synchronized serial clock and chip select, shifts
// bits in MSB first while selected, and counts them. On the chip-select
// rising edge it issues either a write strobe (count equals the frame length)
// or an error strobe (any other count).
// Assumes: inputs are already synchronized to clk, and clk is at least 4x the
// serial clock, so every serial level lasts two or more clk cycles.
module serial_cfg_shifter #(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_clk,
    input  logic              s_csn,
    input  logic              s_dat,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_err
);

    localparam int unsigned FRAME_LEN = DATA_W + ADDR_W;
    localparam int unsigned CNT_MAX   = FRAME_LEN + 1;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    logic                 clk_d;
    logic                 csn_d;
    logic                 clk_rise;
    logic                 csn_rise;
    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     bit_cnt;

    assign clk_rise = s_clk & ~clk_d;
    assign csn_rise = s_csn & ~csn_d;

    // Keep last-cycle copies of serial clock and chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            clk_d <= s_clk;
            csn_d <= s_csn;
        end
    end

    // Shift one bit in on each serial clock rise while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (!s_csn && clk_rise) begin
            shreg <= {shreg[FRAME_LEN-2:0], s_dat};
        end
    end

    // Count bits in the frame, saturating one above the frame length. Clear while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (s_csn) begin
            bit_cnt <= '0;
        end else if (clk_rise && bit_cnt != CNT_W'(CNT_MAX)) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Make the load or error pulse on the chip-select rise, and decode the fields there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb    <= 1'b0;
            frame_err <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_stb    <= 1'b0;
            frame_err <= 1'b0;
            if (csn_rise) begin
                if (bit_cnt == CNT_W'(FRAME_LEN)) begin
                    wr_stb  <= 1'b1;
                    wr_addr <= shreg[ADDR_W-1:0];
                    wr_data <= shreg[FRAME_LEN-1:ADDR_W];
                end else begin
                    frame_err <= 1'b1;
                end
            end
        end
    end

    // R6: the write strobe lasts a single cycle.
    assert_single_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5: a frame is either committed or rejected, never both.
    assert_stb_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && frame_err));

    // R5: the error strobe lasts a single cycle.
    assert_single_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R7: the counter is zero after any cycle spent deselected.
    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_csn) |-> (bit_cnt == '0));

    // R3: the shift register holds while chip select stays high.
    assert_ignore_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_csn && $past(s_csn)) |-> $stable(shreg));

    // R5: the counter never passes its saturation value.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/serial_cfg_bank.sv
`timescale 1ns/1ps
// Module: serial_cfg_bank
// Register bank that the write strobe updates. The top WIDE_CNT-th and later
// registers keep only the low NARROW_W bits. The rest of the incoming field is
// dropped.
// Assumes: wr_addr and wr_data are valid only in the cycle wr_stb is high.
module serial_cfg_bank #(
    parameter int unsigned DATA_W   = 14,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned WIDE_CNT = 12,
    parameter int unsigned NARROW_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_stb,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [(1<<ADDR_W)*DATA_W-1:0]    cfg_regs
);

    import serial_cfg_pkg::*;

    localparam int unsigned NUM_REGS = 1 << ADDR_W;

    for (genvar gi = 0; gi < int'(NUM_REGS); gi++) begin : g_reg
        localparam int unsigned KEEP = (gi >= int'(WIDE_CNT)) ? NARROW_W : DATA_W;
        localparam logic [31:0] MASK32 = low_mask(KEEP);
        localparam logic [DATA_W-1:0] MASK = MASK32[DATA_W-1:0];

        logic [DATA_W-1:0] r_q;

        // Store the masked data field when this register is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (wr_stb && wr_addr == ADDR_W'(gi)) begin
                r_q <= wr_data & MASK;
            end
        end

        assign cfg_regs[gi*DATA_W +: DATA_W] = r_q;

        if (KEEP < DATA_W) begin : g_narrow
            // R8: unused upper bits of a narrow register stay zero.
            assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (r_q & ~MASK) == '0);
        end
    end

    // R10: the bank holds all its contents unless a write strobe came in.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(cfg_regs));

endmodule

// File: rtl/serial_cfg_rx.sv
`timescale 1ns/1ps
// Module: serial_cfg_rx (top)
// Three-wire serial register-write receiver. It synchronizes the serial
// inputs, assembles data-then-address frames, and writes them into the bank
// when chip select rises.
// Assumes: clk is at least 4x the serial clock.
module serial_cfg_rx #(
    parameter int unsigned DATA_W   = serial_cfg_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W   = serial_cfg_pkg::DEF_ADDR_W,
    parameter int unsigned SYNC_N   = serial_cfg_pkg::DEF_SYNC_N,
    parameter int unsigned WIDE_CNT = serial_cfg_pkg::DEF_WIDE_CNT,
    parameter int unsigned NARROW_W = serial_cfg_pkg::DEF_NARROW_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_clk,
    input  logic                          ser_csn,
    input  logic                          ser_dat,
    output logic [(1<<ADDR_W)*DATA_W-1:0] cfg_regs,
    output logic                          wr_stb,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [DATA_W-1:0]             wr_data,
    output logic                          frame_err
);

    logic [2:0] sync_v;

    // Bit order: [2] data, [1] chip select (resets high), [0] clock.
    serial_cfg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_N),
        .RST_VAL (3'b010)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_dat, ser_csn, ser_clk}),
        .sync_out (sync_v)
    );

    serial_cfg_shifter #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_clk     (sync_v[0]),
        .s_csn     (sync_v[1]),
        .s_dat     (sync_v[2]),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_err (frame_err)
    );

    serial_cfg_bank #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .WIDE_CNT (WIDE_CNT),
        .NARROW_W (NARROW_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_regs (cfg_regs)
    );

endmodule

// File: tb/serial_cfg_rx_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 40;
    localparam int NREG       = 16;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic [3:0]  addr;
        logic [13:0] data;
        logic        idle_hi;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  14'h3FFF, 1'b0},
        '{4'd1,  14'h2AAA, 1'b1},
        '{4'd5,  14'h0001, 1'b0},
        '{4'd12, 14'h3FFF, 1'b1},
        '{4'd15, 14'h1234, 1'b0},
        '{4'd7,  14'h2000, 1'b1},
        '{4'd0,  14'h1555, 1'b0},
        '{4'd11, 14'h0F0F, 1'b1},
        '{4'd14, 14'h00A5, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_clk = 1'b0;
    logic          ser_csn = 1'b1;
    logic          ser_dat = 1'b0;
    logic [223:0]  cfg_regs;
    logic          wr_stb;
    logic [3:0]    wr_addr;
    logic [13:0]   wr_data;
    logic          frame_err;

    int checks = 0;
    int errors = 0;
    int stb_n = 0;
    int err_n = 0;
    logic [3:0]  cap_addr;
    logic [13:0] cap_data;
    logic [13:0] exp_regs [NREG];

    serial_cfg_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_csn   (ser_csn),
        .ser_dat   (ser_dat),
        .cfg_regs  (cfg_regs),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_err (frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count strobe cycles away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_n++;
                cap_addr = wr_addr;
                cap_data = wr_data;
            end
            if (frame_err) err_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] model_keep(input logic [3:0] a, input logic [13:0] d);
        return (a >= 4'd12) ? (d & 14'h00FF) : d;
    endfunction

    task automatic send_bits(input logic [31:0] bits, input int n, input bit idle_hi);
        ser_csn = 1'b0;
        #(SCK_HALF);
        for (int i = n - 1; i >= 0; i--) begin
            ser_clk = 1'b0;
            ser_dat = bits[i];
            #(SCK_HALF);
            ser_clk = 1'b1;
            #(SCK_HALF);
        end
        if (!idle_hi) begin
            ser_clk = 1'b0;
            #(SCK_HALF);
        end
        ser_csn = 1'b1;
        #(SCK_HALF);
        ser_clk = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        int bad;
        bad = 0;
        for (int r = 0; r < NREG; r++) begin
            if (cfg_regs[r*14 +: 14] !== exp_regs[r]) begin
                bad++;
                $display("FAIL %s reg%0d actual=%0h expected=%0h", req, r,
                         cfg_regs[r*14 +: 14], exp_regs[r]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic good_frame(input logic [3:0] a, input logic [13:0] d, input bit idle_hi,
                              input string req);
        int s0;
        int e0;
        s0 = stb_n;
        e0 = err_n;
        send_bits({14'b0, d, a}, 18, idle_hi);
        exp_regs[a] = model_keep(a, d);
        check({req, " R6 one strobe"}, stb_n - s0, 1);
        check({req, " R6 no error"}, err_n - e0, 0);
        check({req, " R6 strobe addr"}, cap_addr, a);
        check({req, " R6 strobe data"}, cap_data, d);
        check({req, " R1 reg value"}, cfg_regs[a*14 +: 14], exp_regs[a]);
        check_bank({req, " R10 bank"});
    endtask

    task automatic bad_frame(input logic [31:0] bits, input int n, input string req);
        int s0;
        int e0;
        s0 = stb_n;
        e0 = err_n;
        send_bits(bits, n, 1'b0);
        check({req, " R5 no strobe"}, stb_n - s0, 0);
        check({req, " R5 one error"}, err_n - e0, 1);
        check_bank({req, " R5 bank unchanged"});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) exp_regs[r] = '0;
        repeat (5) @(negedge clk);
        // R9: reset state
        check("R9 wr_stb in reset", wr_stb, 0);
        check("R9 frame_err in reset", frame_err, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_bank("R9 bank zero after reset");

        // R1 R2 R4 R8: table walk
        for (int v = 0; v < NVEC; v++) begin
            good_frame(VECS[v].addr, VECS[v].data, VECS[v].idle_hi, "R1 R2 R4 R8 vec");
        end
        check("R8 narrow reg12", cfg_regs[12*14 +: 14], 14'h00FF);
        check("R8 narrow reg15", cfg_regs[15*14 +: 14], 14'h0034);
        check("R2 msb first reg1", cfg_regs[1*14 +: 14], 14'h2AAA);

        // R3: clock pulses while deselected
        begin
            int s0;
            int e0;
            s0 = stb_n;
            e0 = err_n;
            ser_dat = 1'b1;
            for (int k = 0; k < 5; k++) begin
                ser_clk = 1'b1; #(SCK_HALF);
                ser_clk = 1'b0; #(SCK_HALF);
            end
            repeat (10) @(negedge clk);
            check("R3 no strobe from idle clocks", stb_n - s0, 0);
            check("R3 no error from idle clocks", err_n - e0, 0);
            check_bank("R3 bank after idle clocks");
            good_frame(4'd3, 14'h0C3A, 1'b0, "R3 after idle clocks");
        end

        // R5 R7: short, long and empty frames, each followed by a good one
        bad_frame({14'b0, 14'h3FFF, 4'd2} >> 1, 17, "R5 short17");
        good_frame(4'd2, 14'h1111, 1'b1, "R7 after short");
        bad_frame({13'b0, 1'b1, 14'h0ABC, 4'd4}, 19, "R5 long19");
        good_frame(4'd4, 14'h2222, 1'b0, "R7 after long");
        bad_frame(32'd0, 0, "R5 empty");
        good_frame(4'd9, 14'h3333, 1'b1, "R7 after empty");

        // R9: reset again clears everything
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int r = 0; r < NREG; r++) exp_regs[r] = '0;
        check_bank("R9 bank zero after second reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule